// File: doc/BRIEF.md
# Microprogram Sequencer with Dispatch

This block is the address engine of a horizontally microcoded control unit. It holds the micro-program counter (micro-PC) and keeps the microprogram in a writable control store of 1024 words. The current microword is read out of that store in the same cycle. Its micro-operation bits drive the datapath control lines directly. Its clock-enable bits tell the clock gating logic which functional units are needed in that cycle.

Each microword also carries sequencing information. From that information the block selects the next micro-address. The choices are:
- step to the next address,
- jump, either always or on a tested status flag,
- dispatch through an opcode-indexed mapping table,
- call or return from a micro-subroutine, using a small return stack.

Two external events can override that choice. A fault forces the fault vector and latches the program counter of the faulting instruction. A breakpoint match at the fetch-start address forces the debug vector.

Both tables are loaded through plain write ports. Software or a boot engine normally fills them while reset is held. The datapath, main-memory fetch and operating-system fault handling are outside this block.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low the micro-PC is 0, `stk_err_o` is 0 and `capture_o` is 0; the return stack is emptied.
- R2: Microword layout (67 bits): [47:0] micro-operations, [50:48] unit clock enables (bit 48 ALU, 49 multiplier, 50 shifter), [53:51] condition code, [63:54] target address, [65:64] sequencing kind, [66] return select. With kind 00 the next micro-PC is micro-PC + 1, and it wraps from 1023 to 0.
- R3: With kind 01 the next micro-PC is the target field when the selected condition is true, else micro-PC + 1. Condition code 0 is always true. Code k (1..7) tests `stat_i[k-1]`: code 1 is zero, code 2 is negative, code 3 is carry.
- R4: With kind 10 the next micro-PC is the mapping-table entry indexed by `opcode_i`.
- R5: With kind 11 and return select 0, micro-PC + 1 is pushed and the target field becomes the next micro-PC. With return select 1, the top entry is popped into the micro-PC.
- R6: The return stack holds 4 entries. A call on a full stack still jumps, but the push is dropped. A return on an empty stack falls through to micro-PC + 1. In both cases the stack is left unchanged and the sticky `stk_err_o` is set; only reset clears it.
- R7: `ctrl_o` and `clk_en_o` show the fields of the microword at the current micro-PC in the same cycle, whatever the branch outcome.
- R8: A high `fault_i` overrides every other next-address source except reset, and the next micro-PC is FAULT_VEC (1000). In that following cycle `capture_o` is high for one cycle and `fault_pc_o` holds the `pc_i` value seen with the fault.
- R9: With no fault, if the micro-PC equals FETCH_ADDR (16), `bp_en_i` is high and `pc_i` equals `bp_addr_i`, the next micro-PC is DEBUG_VEC (1008). At any other micro-PC, or with `bp_en_i` low, the breakpoint has no effect.
- R10: A control-store or mapping-table write takes effect from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_we_i | input | 1 | Control-store write strobe |
| cs_waddr_i | input | 10 | Control-store write address |
| cs_wdata_i | input | 67 | Microword to write |
| map_we_i | input | 1 | Mapping-table write strobe |
| map_wopc_i | input | 6 | Opcode slot to write |
| map_waddr_i | input | 10 | Routine start address for that opcode |
| opcode_i | input | 6 | Opcode of the current machine instruction |
| stat_i | input | 7 | Status flags tested by condition codes 1..7 |
| fault_i | input | 1 | Fault request |
| pc_i | input | 16 | Program counter of the current machine instruction |
| bp_en_i | input | 1 | Breakpoint enable |
| bp_addr_i | input | 16 | Breakpoint address |
| upc_o | output | 10 | Current micro-PC |
| ctrl_o | output | 48 | Datapath control lines |
| clk_en_o | output | 3 | Unit clock enables (ALU, multiplier, shifter) |
| capture_o | output | 1 | One-cycle strobe: faulting PC captured |
| fault_pc_o | output | 16 | Captured faulting PC |
| stk_err_o | output | 1 | Sticky return-stack overflow/underflow flag |

## Verification
The properties assume that every input is driven to a known value once reset is released. They also assume that no location reached by the microprogram is left unwritten, because a word of unknown value would make the sequencing kind undefined. To satisfy this, the stimulus loads the whole microprogram and the mapping table while reset is held. It only dispatches on opcodes whose slots it has written, and it changes inputs one nanosecond after the rising edge. Faults are raised at arbitrary micro-addresses, including while a breakpoint match is present, so the priority order is exercised without any hold-time assumption on `fault_i`.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    SQ_NEXT = 2'b00,
    SQ_JUMP = 2'b01,
    SQ_DISP = 2'b10,
    SQ_SUB  = 2'b11
  } seq_kind_e;
endpackage

// File: rtl/useq_table.sv
module useq_table #(
  parameter int AW = 10,
  parameter int DW = 67
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         err_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [W-1:0]     ent [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;
  logic             full;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign top_o   = ent[IDX_W'(cnt_q - CNT_W'(1))];
  assign err_o   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (push) begin
      if (full) err_q <= 1'b1;
      else      cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop) begin
      if (empty_o) err_q <= 1'b1;
      else         cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) ent[IDX_W'(cnt_q)] <= din;
  end

  AST_STK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R6
  AST_STK_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (cnt_q == $past(cnt_q) && err_q)); // R6
  AST_STK_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty_o) |=> (empty_o && err_q)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R6
  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop)); // R5
endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
  import useq_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int COND_W    = 3,
  parameter int FAULT_VEC = 1000,
  parameter int DEBUG_VEC = 1008
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          upc,
  input  seq_kind_e                  kind,
  input  logic                       ret_sel,
  input  logic [COND_W-1:0]          cond,
  input  logic [ADDR_W-1:0]          target,
  input  logic [(1<<COND_W)-2:0]     stat,
  input  logic [ADDR_W-1:0]          map_addr,
  input  logic [ADDR_W-1:0]          stk_top,
  input  logic                       stk_empty,
  input  logic                       fault,
  input  logic                       bkpt_hit,
  output logic [ADDR_W-1:0]          next_upc,
  output logic [ADDR_W-1:0]          ret_addr,
  output logic                       push,
  output logic                       pop
);
  logic [(1<<COND_W)-1:0] cond_vec;
  logic                   cond_ok;
  logic [ADDR_W-1:0]      inc;

  assign cond_vec = {stat, 1'b1};
  assign cond_ok  = cond_vec[cond];
  assign inc      = upc + ADDR_W'(1);
  assign ret_addr = inc;

  always_comb begin
    push     = 1'b0;
    pop      = 1'b0;
    next_upc = inc;
    if (fault) begin
      next_upc = ADDR_W'(FAULT_VEC);
    end else if (bkpt_hit) begin
      next_upc = ADDR_W'(DEBUG_VEC);
    end else begin
      unique case (kind)
        SQ_NEXT: next_upc = inc;
        SQ_JUMP: next_upc = cond_ok ? target : inc;
        SQ_DISP: next_upc = map_addr;
        SQ_SUB: begin
          if (ret_sel) begin
            pop      = 1'b1;
            next_upc = stk_empty ? inc : stk_top;
          end else begin
            push     = 1'b1;
            next_upc = target;
          end
        end
        default: next_upc = inc;
      endcase
    end
  end

  AST_OVERRIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fault || bkpt_hit) |-> !(push || pop)); // R8
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int OPS_W      = 48,
  parameter int GATE_W     = 3,
  parameter int ADDR_W     = 10,
  parameter int COND_W     = 3,
  parameter int OPC_W      = 6,
  parameter int PC_W       = 16,
  parameter int STK_DEPTH  = 4,
  parameter int FETCH_ADDR = 16,
  parameter int FAULT_VEC  = 1000,
  parameter int DEBUG_VEC  = 1008,
  localparam int STAT_W    = (1 << COND_W) - 1,
  localparam int GATE_LO   = OPS_W,
  localparam int COND_LO   = GATE_LO + GATE_W,
  localparam int TGT_LO    = COND_LO + COND_W,
  localparam int KIND_LO   = TGT_LO + ADDR_W,
  localparam int RET_BIT   = KIND_LO + 2,
  localparam int WORD_W    = RET_BIT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_we_i,
  input  logic [ADDR_W-1:0] cs_waddr_i,
  input  logic [WORD_W-1:0] cs_wdata_i,
  input  logic              map_we_i,
  input  logic [OPC_W-1:0]  map_wopc_i,
  input  logic [ADDR_W-1:0] map_waddr_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              fault_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              bp_en_i,
  input  logic [PC_W-1:0]   bp_addr_i,
  output logic [ADDR_W-1:0] upc_o,
  output logic [OPS_W-1:0]  ctrl_o,
  output logic [GATE_W-1:0] clk_en_o,
  output logic              capture_o,
  output logic [PC_W-1:0]   fault_pc_o,
  output logic              stk_err_o
);
  logic [ADDR_W-1:0] upc_q;
  logic              cap_q;
  logic [PC_W-1:0]   fpc_q;
  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] map_addr;
  logic [ADDR_W-1:0] stk_top;
  logic              stk_empty;
  logic [ADDR_W-1:0] next_upc;
  logic [ADDR_W-1:0] ret_addr;
  logic              push;
  logic              pop;
  logic              bkpt_hit;
  seq_kind_e         kind;

  useq_table #(.AW(ADDR_W), .DW(WORD_W)) u_cstore (
    .clk   (clk),
    .we    (cs_we_i),
    .waddr (cs_waddr_i),
    .wdata (cs_wdata_i),
    .raddr (upc_q),
    .rdata (word)
  );

  useq_table #(.AW(OPC_W), .DW(ADDR_W)) u_dmap (
    .clk   (clk),
    .we    (map_we_i),
    .waddr (map_wopc_i),
    .wdata (map_waddr_i),
    .raddr (opcode_i),
    .rdata (map_addr)
  );

  assign kind     = seq_kind_e'(word[KIND_LO +: 2]);
  assign bkpt_hit = bp_en_i && (upc_q == ADDR_W'(FETCH_ADDR)) && (pc_i == bp_addr_i);

  useq_nextaddr #(
    .ADDR_W    (ADDR_W),
    .COND_W    (COND_W),
    .FAULT_VEC (FAULT_VEC),
    .DEBUG_VEC (DEBUG_VEC)
  ) u_next (
    .clk       (clk),
    .rst_n     (rst_n),
    .upc       (upc_q),
    .kind      (kind),
    .ret_sel   (word[RET_BIT]),
    .cond      (word[COND_LO +: COND_W]),
    .target    (word[TGT_LO +: ADDR_W]),
    .stat      (stat_i),
    .map_addr  (map_addr),
    .stk_top   (stk_top),
    .stk_empty (stk_empty),
    .fault     (fault_i),
    .bkpt_hit  (bkpt_hit),
    .next_upc  (next_upc),
    .ret_addr  (ret_addr),
    .push      (push),
    .pop       (pop)
  );

  useq_stack #(.DEPTH(STK_DEPTH), .W(ADDR_W)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .pop     (pop),
    .din     (ret_addr),
    .top_o   (stk_top),
    .empty_o (stk_empty),
    .err_o   (stk_err_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upc_q <= '0;
      cap_q <= 1'b0;
      fpc_q <= '0;
    end else begin
      upc_q <= next_upc;
      cap_q <= fault_i;
      if (fault_i) fpc_q <= pc_i;
    end
  end

  assign upc_o      = upc_q;
  assign ctrl_o     = word[OPS_W-1:0];
  assign clk_en_o   = word[GATE_LO +: GATE_W];
  assign capture_o  = cap_q;
  assign fault_pc_o = fpc_q;

  AST_RST_ZERO: assert property (@(posedge clk)
    !rst_n |=> (upc_q == '0 && !cap_q)); // R1
  AST_FAULT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (upc_q == ADDR_W'(FAULT_VEC) && fpc_q == $past(pc_i))); // R8
  AST_CAPTURE_AT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |-> (upc_q == ADDR_W'(FAULT_VEC))); // R8
  AST_BKPT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (bkpt_hit && !fault_i) |=> (upc_q == ADDR_W'(DEBUG_VEC))); // R9
  AST_NEXT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_i && !bkpt_hit && kind == SQ_NEXT) |=> (upc_q == $past(upc_q) + ADDR_W'(1))); // R2
  AST_DISP_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_i && !bkpt_hit && kind == SQ_DISP) |=> (upc_q == $past(map_addr))); // R4
endmodule

// File: tb/tb_useq_sequencer.sv
module tb_useq_sequencer;
  localparam int AW = 10;
  localparam int WW = 67;
  localparam int NV = 20;

  logic          clk;
  logic          rst_n;
  logic          cs_we;
  logic [AW-1:0] cs_waddr;
  logic [WW-1:0] cs_wdata;
  logic          map_we;
  logic [5:0]    map_wopc;
  logic [AW-1:0] map_waddr;
  logic [5:0]    opcode;
  logic [6:0]    stat;
  logic          fault;
  logic [15:0]   pc;
  logic          bp_en;
  logic [15:0]   bp_addr;
  logic [AW-1:0] upc;
  logic [47:0]   ctrl;
  logic [2:0]    clk_en;
  logic          capture;
  logic [15:0]   fault_pc;
  logic          stk_err;

  int total = 0;
  int bad   = 0;
  logic [WW-1:0] prog [1024];

  useq_sequencer dut (
    .clk(clk), .rst_n(rst_n),
    .cs_we_i(cs_we), .cs_waddr_i(cs_waddr), .cs_wdata_i(cs_wdata),
    .map_we_i(map_we), .map_wopc_i(map_wopc), .map_waddr_i(map_waddr),
    .opcode_i(opcode), .stat_i(stat), .fault_i(fault), .pc_i(pc),
    .bp_en_i(bp_en), .bp_addr_i(bp_addr),
    .upc_o(upc), .ctrl_o(ctrl), .clk_en_o(clk_en), .capture_o(capture),
    .fault_pc_o(fault_pc), .stk_err_o(stk_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // stat (7) | opcode (6) | expected micro-PC after the edge (10)
  localparam logic [22:0] VEC [NV] = '{
    {7'b0000000, 6'd0,  10'd1},    // R2 step
    {7'b0000000, 6'd0,  10'd16},   // R3 always
    {7'b0000000, 6'd5,  10'd200},  // R4 dispatch
    {7'b0000110, 6'd5,  10'd201},  // R3 zero false
    {7'b0000100, 6'd0,  10'd220},  // R3 carry true
    {7'b0000000, 6'd0,  10'd400},  // R5 call
    {7'b0000000, 6'd0,  10'd401},
    {7'b0000000, 6'd0,  10'd221},  // R5 return
    {7'b0000000, 6'd0,  10'd16},
    {7'b0000000, 6'd9,  10'd300},  // R4
    {7'b0000000, 6'd0,  10'd500},  // R5 call
    {7'b0000000, 6'd0,  10'd301},  // R5 return
    {7'b0000000, 6'd0,  10'd16},
    {7'b0000000, 6'd5,  10'd200},
    {7'b0000001, 6'd0,  10'd210},  // R3 zero true
    {7'b0000000, 6'd0,  10'd16},
    {7'b0000000, 6'd5,  10'd200},
    {7'b0000000, 6'd0,  10'd201},
    {7'b0000011, 6'd0,  10'd202},  // R3 carry false
    {7'b0000000, 6'd0,  10'd16}
  };

  task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [WW-1:0] mkw(input logic [1:0] kind, input logic ret,
                                        input logic [AW-1:0] tgt, input logic [2:0] cond,
                                        input logic [AW-1:0] a);
    return {ret, kind, tgt, cond, a[2:0] ^ 3'b101, a, 38'h15A5A5A5A5};
  endfunction

  task automatic put(input int a, input logic [1:0] kind, input logic ret,
                     input int tgt, input logic [2:0] cond);
    logic [WW-1:0] w;
    w = mkw(kind, ret, AW'(tgt), cond, AW'(a));
    prog[a]  = w;
    cs_we    = 1'b1;
    cs_waddr = AW'(a);
    cs_wdata = w;
    step();
    cs_we    = 1'b0;
  endtask

  task automatic pmap(input int opc, input int a);
    map_we    = 1'b1;
    map_wopc  = 6'(opc);
    map_waddr = AW'(a);
    step();
    map_we    = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] cur;
    logic [WW-1:0] w2;
    for (int i = 0; i < 1024; i++) prog[i] = '0;
    rst_n = 1'b0; cs_we = 1'b0; cs_waddr = '0; cs_wdata = '0;
    map_we = 1'b0; map_wopc = '0; map_waddr = '0; opcode = '0; stat = '0;
    fault = 1'b0; pc = '0; bp_en = 1'b0; bp_addr = '0;
    step();
    // program load under reset
    put(0, 2'b00, 0, 0, 0);     put(1, 2'b01, 0, 16, 0);
    put(16, 2'b10, 0, 0, 0);
    put(200, 2'b01, 0, 210, 1); put(201, 2'b01, 0, 220, 3);
    put(202, 2'b01, 0, 16, 0);  put(210, 2'b01, 0, 16, 0);
    put(220, 2'b11, 0, 400, 0); put(221, 2'b01, 0, 16, 0);
    put(400, 2'b00, 0, 0, 0);   put(401, 2'b11, 1, 0, 0);
    put(300, 2'b11, 0, 500, 0); put(301, 2'b01, 0, 16, 0);
    put(500, 2'b11, 1, 0, 0);
    put(600, 2'b11, 0, 610, 0); put(610, 2'b11, 0, 620, 0);
    put(620, 2'b11, 0, 630, 0); put(630, 2'b11, 0, 640, 0);
    put(640, 2'b11, 0, 650, 0); put(650, 2'b11, 1, 0, 0);
    put(631, 2'b11, 1, 0, 0);   put(621, 2'b11, 1, 0, 0);
    put(611, 2'b11, 1, 0, 0);   put(601, 2'b11, 1, 0, 0);
    put(602, 2'b01, 0, 16, 0);  put(250, 2'b01, 0, 16, 0);
    put(1000, 2'b11, 1, 0, 0);  put(1001, 2'b01, 0, 16, 0);
    put(1008, 2'b01, 0, 1008, 0); put(1023, 2'b00, 0, 0, 0);
    pmap(5, 200); pmap(9, 300); pmap(12, 600); pmap(20, 1023);

    check("R1 upc in reset", WW'(upc), WW'(0));
    check("R1 err in reset", WW'(stk_err), WW'(0));
    check("R1 capture in reset", WW'(capture), WW'(0));
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 with R7 output check before each edge
    cur = '0;
    for (int i = 0; i < NV; i++) begin
      stat   = VEC[i][22:16];
      opcode = VEC[i][15:10];
      check("R7 ctrl", WW'(ctrl), WW'(prog[cur][47:0]));
      check("R7 clk_en", WW'(clk_en), WW'(prog[cur][50:48]));
      step();
      check("R2 R3 R4 R5 walk upc", WW'(upc), WW'(VEC[i][9:0]));
      cur = VEC[i][9:0];
    end
    stat = '0;

    // R6 overflow then underflow
    opcode = 6'd12; step(); check("R4 dispatch 12", WW'(upc), WW'(600));
    step(); step(); step(); step();
    check("R5 fourth call", WW'(upc), WW'(640));
    check("R6 no error at 4 deep", WW'(stk_err), WW'(0));
    step(); check("R6 call on full jumps", WW'(upc), WW'(650));
    check("R6 overflow flag", WW'(stk_err), WW'(1));
    step(); check("R6 stack unchanged by dropped push", WW'(upc), WW'(631));
    step(); step(); step(); check("R5 unwind", WW'(upc), WW'(601));
    step(); check("R6 return on empty falls through", WW'(upc), WW'(602));
    check("R6 flag sticky", WW'(stk_err), WW'(1));
    step(); check("R3 back to fetch", WW'(upc), WW'(16));

    // R9 breakpoint
    bp_en = 1'b1; bp_addr = 16'h0040; pc = 16'h0040;
    step(); check("R9 breakpoint vector", WW'(upc), WW'(1008));
    step(); check("R9 no effect off fetch", WW'(upc), WW'(1008));
    // R10 control store rewrite
    w2 = {1'b0, 2'b01, 10'd1008, 3'd0, 3'b110, 48'hDEAD_BEEF_0001};
    cs_we = 1'b1; cs_waddr = 10'd1008; cs_wdata = w2;
    step(); cs_we = 1'b0;
    check("R10 new ctrl", WW'(ctrl), WW'(48'hDEAD_BEEF_0001));
    check("R10 new clk_en", WW'(clk_en), WW'(3'b110));
    // R8 fault
    fault = 1'b1; pc = 16'h1234;
    step();
    check("R8 fault vector", WW'(upc), WW'(1000));
    check("R8 capture strobe", WW'(capture), WW'(1));
    check("R8 captured pc", WW'(fault_pc), WW'(16'h1234));
    fault = 1'b0;
    map_we = 1'b1; map_wopc = 6'd5; map_waddr = 10'd250;
    step(); map_we = 1'b0;
    check("R8 strobe one cycle", WW'(capture), WW'(0));
    check("R6 return on empty at handler", WW'(upc), WW'(1001));
    step(); check("R3 handler exit", WW'(upc), WW'(16));
    // R8 fault beats breakpoint
    fault = 1'b1; pc = 16'h0040;
    step(); check("R8 priority over breakpoint", WW'(upc), WW'(1000));
    check("R8 captured pc 2", WW'(fault_pc), WW'(16'h0040));
    fault = 1'b0;
    step(); step(); check("R8 return to fetch", WW'(upc), WW'(16));
    // R9 disabled, R10 map rewrite
    bp_en = 1'b0; opcode = 6'd5;
    step(); check("R9 R10 disabled bp, new map entry", WW'(upc), WW'(250));
    step(); opcode = 6'd20;
    step(); check("R4 dispatch to top", WW'(upc), WW'(1023));
    step(); check("R2 wrap", WW'(upc), WW'(0));

    // reset again, then underflow
    rst_n = 1'b0; step();
    check("R1 upc after reset", WW'(upc), WW'(0));
    check("R1 err cleared", WW'(stk_err), WW'(0));
    rst_n = 1'b1;
    fault = 1'b1; step(); fault = 1'b0;
    check("R8 fault from 0", WW'(upc), WW'(1000));
    step();
    check("R6 underflow falls through", WW'(upc), WW'(1001));
    check("R6 underflow flag", WW'(stk_err), WW'(1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule